// File: doc/BRIEF.md
# Per-Pin Interrupt and Wake Event Detector

This block watches one pin's already-filtered input level. It turns transitions or levels on that input into two sticky status bits: an interrupt status and a wake status. Configuration inputs choose between edge and level detection, and a 2-bit polarity code picks rising, falling or both edges. An interrupt enable controls whether the interrupt status may latch. A separate unmask bit controls whether a latched status is forwarded as a request to a summary aggregator. Three wake enables cover three sleep states. The current power state picks which one of them applies.

Software clears either status bit with a write-one-to-clear strobe. When an event arrives in the same cycle as a clear, the event takes priority. The block also returns a registered copy of the pin level for readback.

Top module: `pin_event_detector`

## Requirements
- R1: After reset (asynchronous, active low) the interrupt status, wake status, request and level readback are all 0. A reset in the middle of operation returns them to 0.
- R2: In edge mode (`cfg_level_mode`=0) with polarity code 0, a rising transition sets the interrupt status. This is a 0→1 change of `level_in` between the level sampled at the previous clock edge and the level at the current edge. A falling transition does not set it. The status is visible after that clock edge.
- R3: In edge mode with polarity code 1, only a falling transition (1→0) sets the interrupt status.
- R4: In edge mode with polarity code 2, both rising and falling transitions set the interrupt status. Polarity code 3 never produces an event.
- R5: In level mode (`cfg_level_mode`=1), code 0 sets the status on every cycle that `level_in` is 1, and code 1 sets it on every cycle that `level_in` is 0. Codes 2 and 3 produce no event in level mode.
- R6: The interrupt status can only be set while `cfg_int_en`=1. Clearing `cfg_int_en` does not clear a status that is already set.
- R7: `irq_req` is 1 exactly when the interrupt status is 1 and `cfg_unmask`=1. The unmask bit never changes the status itself.
- R8: A cycle with `clr_wr`=1 and `clr_int_bit`=1 clears the interrupt status. `clr_int_bit` has no effect when `clr_wr`=0. If an enabled event occurs in the same cycle as a clear, the status stays 1.
- R9: An event sets the wake status only when the wake enable for the current power state is 1, independently of `cfg_int_en`. Power state encoding: 0 running, 1 idle, 2 suspend-to-RAM, 3 hibernate. Wake enable bit 0 applies to idle, bit 1 to suspend and bit 2 to hibernate. In the running state the wake status is never set.
- R10: A cycle with `clr_wr`=1 and `clr_wake_bit`=1 clears the wake status, unless a qualifying wake event occurs in the same cycle.
- R11: `level_rd` equals the value of `level_in` at the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_in | input | 1 | Filtered pin level |
| cfg_level_mode | input | 1 | 0 edge detection, 1 level detection |
| cfg_polarity | input | 2 | 0 high/rising, 1 low/falling, 2 both edges, 3 none |
| cfg_int_en | input | 1 | Allows the interrupt status to latch |
| cfg_unmask | input | 1 | 1 forwards the latched status as a request |
| cfg_wake_en | input | NUM_SLEEP | Wake enable per sleep state (bit 0 idle, 1 suspend, 2 hibernate) |
| pwr_state | input | PWR_W | Current power state, 0 is running |
| clr_wr | input | 1 | Status write strobe |
| clr_int_bit | input | 1 | Write-one-to-clear data for the interrupt status |
| clr_wake_bit | input | 1 | Write-one-to-clear data for the wake status |
| level_rd | output | 1 | Registered pin level readback |
| int_sts | output | 1 | Sticky interrupt status |
| wake_sts | output | 1 | Sticky wake status |
| irq_req | output | 1 | Qualified request to the summary aggregator |

## Verification
On every cycle the assertions check four things:
- the request gating against the unmask bit;
- that a disabled interrupt cannot rise;
- that an enabled event always leaves the status set, including over a simultaneous clear;
- that a clear without an event empties the status, and that the running state never raises wake.

The polarity decoding can only be shown by the bench's ordered scenarios, because it depends on the level history. Those scenarios cover rising-only, falling-only, both-edge, level-high and level-low detection, and also the codes that do nothing. The bench scenarios also cover selecting wake enables by power state, gating clears on the write strobe, and resetting mid-run.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  typedef enum logic [1:0] {
    POL_HIGH = 2'd0,
    POL_LOW  = 2'd1,
    POL_BOTH = 2'd2,
    POL_NONE = 2'd3
  } pol_code_e;

  // Event decision for one cycle from mode, polarity, current and previous level.
  function automatic logic event_hit(input logic level_mode, input pol_code_e pol,
                                     input logic cur, input logic prev);
    logic hit;
    case (pol)
      POL_HIGH: hit = level_mode ? cur  : (cur & ~prev);
      POL_LOW:  hit = level_mode ? ~cur : (~cur & prev);
      POL_BOTH: hit = level_mode ? 1'b0 : (cur ^ prev);
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pin_level_tracker.sv
module pin_level_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end
endmodule

// File: rtl/pin_wake_select.sv
module pin_wake_select #(
  parameter int NUM_SLEEP = 3,
  parameter int PWR_W     = $clog2(NUM_SLEEP + 1)
) (
  input  logic [NUM_SLEEP-1:0] wake_en,
  input  logic [PWR_W-1:0]     pwr_state,
  output logic                 wake_ok
);
  logic [NUM_SLEEP-1:0] state_hit;

  for (genvar g = 0; g < NUM_SLEEP; g++) begin : g_state
    assign state_hit[g] = wake_en[g] && (pwr_state == PWR_W'(g + 1));
  end

  assign wake_ok = |state_hit;
endmodule

// File: rtl/pin_sticky_bit.sv
module pin_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // Set has priority over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pin_evt_pkg::*;
#(
  parameter int NUM_SLEEP = 3,
  parameter int PWR_W     = $clog2(NUM_SLEEP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 level_in,
  input  logic                 cfg_level_mode,
  input  logic [1:0]           cfg_polarity,
  input  logic                 cfg_int_en,
  input  logic                 cfg_unmask,
  input  logic [NUM_SLEEP-1:0] cfg_wake_en,
  input  logic [PWR_W-1:0]     pwr_state,
  input  logic                 clr_wr,
  input  logic                 clr_int_bit,
  input  logic                 clr_wake_bit,
  output logic                 level_rd,
  output logic                 int_sts,
  output logic                 wake_sts,
  output logic                 irq_req
);
  logic level_q;
  logic pin_event;
  logic wake_ok;
  logic int_set;
  logic wake_set;
  logic int_clr;
  logic wake_clr;

  pin_level_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (level_in),
    .level_q  (level_q)
  );

  assign pin_event = event_hit(cfg_level_mode, pol_code_e'(cfg_polarity), level_in, level_q);

  pin_wake_select #(.NUM_SLEEP(NUM_SLEEP), .PWR_W(PWR_W)) u_wsel (
    .wake_en   (cfg_wake_en),
    .pwr_state (pwr_state),
    .wake_ok   (wake_ok)
  );

  assign int_set  = pin_event && cfg_int_en;
  assign wake_set = pin_event && wake_ok;
  assign int_clr  = clr_wr && clr_int_bit;
  assign wake_clr = clr_wr && clr_wake_bit;

  pin_sticky_bit u_int_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (int_set),
    .clr_i (int_clr),
    .q     (int_sts)
  );

  pin_sticky_bit u_wake_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wake_set),
    .clr_i (wake_clr),
    .q     (wake_sts)
  );

  assign level_rd = level_q;
  assign irq_req  = int_sts && cfg_unmask;
endmodule

// File: rtl/pin_event_detector_chk.sv
module pin_event_detector_chk #(
  parameter int PWR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_int_en,
  input logic             cfg_unmask,
  input logic [PWR_W-1:0] pwr_state,
  input logic             clr_wr,
  input logic             clr_int_bit,
  input logic             pin_event,
  input logic             int_sts,
  input logic             wake_sts,
  input logic             irq_req
);
  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unmask) |-> !irq_req);

  // R6
  disabled_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_sts && !cfg_int_en) |=> !int_sts);

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_event && cfg_int_en) |=> int_sts);

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_int_bit && !pin_event) |=> !int_sts);

  // R9
  running_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_sts && pwr_state == '0) |=> !wake_sts);
endmodule

bind pin_event_detector pin_event_detector_chk #(.PWR_W(PWR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_int_en  (cfg_int_en),
  .cfg_unmask  (cfg_unmask),
  .pwr_state   (pwr_state),
  .clr_wr      (clr_wr),
  .clr_int_bit (clr_int_bit),
  .pin_event   (pin_event),
  .int_sts     (int_sts),
  .wake_sts    (wake_sts),
  .irq_req     (irq_req)
);

// File: tb/pin_event_detector_tb.sv
module pin_event_detector_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       level_in, cfg_level_mode, cfg_int_en, cfg_unmask;
  logic [1:0] cfg_polarity;
  logic [2:0] cfg_wake_en;
  logic [1:0] pwr_state;
  logic       clr_wr, clr_int_bit, clr_wake_bit;
  logic       level_rd, int_sts, wake_sts, irq_req;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pin_event_detector u_dut (
    .clk(clk), .rst_n(rst_n), .level_in(level_in), .cfg_level_mode(cfg_level_mode),
    .cfg_polarity(cfg_polarity), .cfg_int_en(cfg_int_en), .cfg_unmask(cfg_unmask),
    .cfg_wake_en(cfg_wake_en), .pwr_state(pwr_state), .clr_wr(clr_wr),
    .clr_int_bit(clr_int_bit), .clr_wake_bit(clr_wake_bit), .level_rd(level_rd),
    .int_sts(int_sts), .wake_sts(wake_sts), .irq_req(irq_req)
  );

  // Fields: level, mode, pol[2], int_en, unmask, wake_en[3], pwr[2], clr_int, clr_wake | exp int, wake, req
  localparam int NV = 29;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_0_00_1_1_000_00_0_0_0_0_0,
    16'b1_0_00_1_1_000_00_0_0_1_0_1,
    16'b1_0_00_1_1_000_00_1_0_0_0_0,
    16'b0_0_00_1_1_000_00_0_0_0_0_0,
    16'b0_0_01_1_1_000_00_0_0_0_0_0,
    16'b1_0_01_1_1_000_00_0_0_0_0_0,
    16'b0_0_01_1_0_000_00_0_0_1_0_0,
    16'b0_0_01_1_1_000_00_0_0_1_0_1,
    16'b0_0_10_1_1_000_00_1_0_0_0_0,
    16'b1_0_10_1_1_000_00_0_0_1_0_1,
    16'b1_0_10_1_1_000_00_1_0_0_0_0,
    16'b0_0_10_1_1_000_00_0_0_1_0_1,
    16'b0_0_10_0_1_000_00_1_0_0_0_0,
    16'b1_0_00_0_1_000_00_0_0_0_0_0,
    16'b1_1_00_1_1_000_00_0_0_1_0_1,
    16'b1_1_00_1_1_000_00_1_0_1_0_1,
    16'b0_1_00_1_1_000_00_1_0_0_0_0,
    16'b0_1_01_1_0_000_00_0_0_1_0_0,
    16'b1_1_01_1_1_000_00_1_0_0_0_0,
    16'b0_0_00_0_1_010_10_0_0_0_0_0,
    16'b1_0_00_0_1_010_10_0_0_0_1_0,
    16'b1_0_00_0_1_010_10_0_1_0_0_0,
    16'b0_0_10_0_1_010_01_0_0_0_0_0,
    16'b1_0_10_0_1_111_00_0_0_0_0_0,
    16'b0_0_10_0_1_100_11_0_0_0_1_0,
    16'b1_0_10_0_1_100_11_0_1_0_1_0,
    16'b1_0_10_0_1_100_11_0_1_0_0_0,
    16'b1_1_10_1_1_000_00_0_0_0_0_0,
    16'b0_0_11_1_1_000_00_0_0_0_0_0
  };

  function automatic string tag_for(input int i);
    if (i < 4)       return "R2";
    else if (i < 6)  return "R3";
    else if (i < 8)  return "R7";
    else if (i < 12) return "R4";
    else if (i < 14) return "R6";
    else if (i < 16) return "R8";
    else if (i < 19) return "R5";
    else if (i < 21) return "R9";
    else if (i == 21 || i >= 25 && i < 27) return "R10";
    else if (i < 25) return "R9";
    else             return "R5";
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    level_in = 0; cfg_level_mode = 0; cfg_polarity = 0; cfg_int_en = 0; cfg_unmask = 0;
    cfg_wake_en = 0; pwr_state = 0; clr_wr = 0; clr_int_bit = 0; clr_wake_bit = 0;
  endtask

  task automatic step_and_sample();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "int_sts", int_sts, 1'b0);
    check("R1", "wake_sts", wake_sts, 1'b0);
    check("R1", "irq_req", irq_req, 1'b0);
    check("R1", "level_rd", level_rd, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      level_in       = VEC[i][15];
      cfg_level_mode = VEC[i][14];
      cfg_polarity   = VEC[i][13:12];
      cfg_int_en     = VEC[i][11];
      cfg_unmask     = VEC[i][10];
      cfg_wake_en    = VEC[i][9:7];
      pwr_state      = VEC[i][6:5];
      clr_int_bit    = VEC[i][4];
      clr_wake_bit   = VEC[i][3];
      clr_wr         = VEC[i][4] | VEC[i][3];
      step_and_sample();
      check(tag_for(i), $sformatf("int_sts v%0d", i), int_sts, VEC[i][2]);
      check(tag_for(i), $sformatf("wake_sts v%0d", i), wake_sts, VEC[i][1]);
      check(tag_for(i), $sformatf("irq_req v%0d", i), irq_req, VEC[i][0]);
      // R11 readback follows the level sampled at this edge
      check("R11", $sformatf("level_rd v%0d", i), level_rd, VEC[i][15]);
    end

    // R8: clear data without the write strobe has no effect
    @(negedge clk);
    idle_inputs();
    level_in = 1; cfg_int_en = 1; cfg_unmask = 1;
    step_and_sample();
    check("R8", "int_sts set before strobe test", int_sts, 1'b1);
    @(negedge clk);
    clr_int_bit = 1; clr_wr = 0;
    step_and_sample();
    check("R8", "int_sts kept without strobe", int_sts, 1'b1);
    check("R7", "irq_req with status and unmask", irq_req, 1'b1);

    // R6: dropping the enable keeps the latched status
    @(negedge clk);
    clr_int_bit = 0; cfg_int_en = 0;
    step_and_sample();
    check("R6", "int_sts held after enable off", int_sts, 1'b1);

    // R10: wake clear needs the strobe too; then reset mid-run (R1)
    @(negedge clk);
    level_in = 0; cfg_polarity = 2'd2; cfg_wake_en = 3'b001; pwr_state = 2'd1;
    step_and_sample();
    check("R9", "wake_sts idle wake", wake_sts, 1'b1);
    @(negedge clk);
    clr_wake_bit = 1; clr_wr = 0;
    step_and_sample();
    check("R10", "wake_sts kept without strobe", wake_sts, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "int_sts async reset", int_sts, 1'b0);
    check("R1", "wake_sts async reset", wake_sts, 1'b0);
    check("R1", "irq_req async reset", irq_req, 1'b0);
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule